// File: doc/BRIEF.md
# Page Hamming ECC generator

This block sits beside the data path of a NAND flash controller and computes a single-error-correcting Hamming code over each 512-byte chunk of a page as the bytes stream past. A page holds up to four chunks (2 KiB). Software arms the engine by writing a non-bypass mode into a small configuration register. The engine then starts counting when the command stream carries one of the programmed start opcodes. It closes the page when the data beat marked as last is accepted.

Each chunk's code is published in its own result word. A result word is selected with a chunk index, which software maps onto registers at 4-byte steps. The word holds the one's complement of the 24-bit parity code, a valid flag and a failed flag. A busy output stays high from the start opcode until the last beat has been taken. Software waits for busy to fall and then reads the result words. It inverts each one and takes three bytes, least significant first, to get the code for the spare area. The correction step itself is done elsewhere.

The data stream is a valid/ready interface. A byte is transferred on a clock edge where both `dat_valid` and `dat_ready` are high. The block lowers `dat_ready` only in a cycle where a start opcode is being recognised, so a byte can never be counted into a page that is being restarted. The source must hold its byte, valid and last flag stable until the byte is accepted.

Top module: `ecc_page_gen`

## Requirements
- R1: After reset `busy` is 0, `cfg_q` is 0 and every result word reads 0.
- R2: `cfg_q` returns the last value written through `cfg_we`. Bits [3:2] are the mode: 0 = bypass, 1 = register-driven, 2 = memory, 3 = reserved, and any non-zero value enables the engine. Bits [1:0] are the page size and give the number of chunks: 1 gives 1, 2 gives 2, and 3 or 0 gives 4.
- R3: With a non-zero mode, a `cmd_valid` cycle starts a page if its opcode equals byte 0 or byte 1 of either opcode register. Starting a page sets `busy` from the next cycle, clears every result word to 0 and zeroes the counters. Bytes 2 and 3 of the opcode registers never start a page, and in bypass mode no opcode starts one. The reset contents are 0x01_30_00_80 for register 0 and 0x01_E0_05_85 for register 1, where `op_sel` selects the register.
- R4: `dat_ready` is 0 exactly in a cycle where a start (R3) is being recognised, and 1 in every other cycle.
- R5: The code of a chunk is twelve parity pairs over the data bits. Each bit has the 12-bit address {byte index within the chunk [11:3], bit index [2:0]}. Code bit k (k = 0..11) is the XOR of all data bits whose address bit k is 1. Code bit 12+k is the XOR of all data bits whose address bit k is 0.
- R6: A result word holds the complement of the code in bits [23:0], the valid flag in bit 30 and the failed flag in bit 28. Bit 27 (correctable) and all other bits read 0.
- R7: While busy, chunk n is published into result word n, valid with failed clear, on the edge that accepts its 512th byte. The next byte begins chunk n+1.
- R8: While busy, bytes accepted after the page's chunk count (R2) has been filled do not change any result word.
- R9: Accepting a beat with `dat_last` high while busy drops `busy` on that edge. If that beat leaves a chunk with fewer than 512 bytes, the chunk is published valid and failed, with the code of the bytes it received.
- R10: Writing bypass mode clears `busy`, all result words and the counters, even in the middle of a page.
- R11: Data bytes and last flags accepted while not busy change neither `busy` nor any result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 4 | Mode [3:2] and page size [1:0] |
| cfg_q | output | 4 | Current configuration value |
| op_we | input | 1 | Write strobe for an opcode register |
| op_sel | input | 1 | Opcode register select (0 or 1) |
| op_wdata | input | 32 | Four opcodes, one per byte |
| cmd_valid | input | 1 | A command opcode is on the bus this cycle |
| cmd_opcode | input | 8 | Command opcode |
| dat_valid | input | 1 | Data byte valid |
| dat_ready | output | 1 | Data byte accepted when high with valid |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | This beat is the last access of the page |
| busy | output | 1 | Page calculation in progress |
| rd_idx | input | 2 | Result word select (chunk number) |
| rd_data | output | 32 | Selected result word |

## Verification
The assertions assume that the command stream and the configuration port do not both act on a page in the same cycle. They also assume that a held data beat stays stable while `dat_ready` is low. The bench keeps to both: it issues commands, configuration writes and data in separate cycles, and it never drives data during a start cycle except where it checks the back-pressure itself. The assertions also rely on `rd_idx` moving only when the bench changes it on a falling edge.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_REG    = 2'd1,
    MODE_MEM    = 2'd2,
    MODE_RSVD   = 2'd3
  } ecc_mode_e;

  localparam int WORD_W      = 32;
  localparam int VALID_BIT   = 30;
  localparam int FAILED_BIT  = 28;
  localparam int CORR_BIT    = 27;
  localparam int OPCODE_W    = 8;
  localparam int OPREG_COUNT = 2;

  localparam logic [31:0] OPREG0_RST = 32'h0130_0080;
  localparam logic [31:0] OPREG1_RST = 32'h01E0_0585;

  // Mask of the bit positions within a byte whose bit index has bit k set.
  function automatic logic [7:0] bit_sel_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) begin
      m[b] = ((b >> k) & 1) == 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_opcode_regs.sv
module ecc_opcode_regs
  import ecc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_we,
  input  logic                op_sel,
  input  logic [31:0]         op_wdata,
  input  logic [OPCODE_W-1:0] cmd_opcode,
  output logic                start_match
);

  logic [31:0]          regs_q [OPREG_COUNT];
  logic [OPREG_COUNT-1:0] hit;

  for (genvar r = 0; r < OPREG_COUNT; r++) begin : g_reg
    localparam logic [31:0] RST_V = (r == 0) ? OPREG0_RST : OPREG1_RST;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= RST_V;
      end else if (op_we && (op_sel == r[0])) begin
        regs_q[r] <= op_wdata;
      end
    end

    // Only the two start opcodes of each register arm the engine.
    assign hit[r] = (cmd_opcode == regs_q[r][7:0]) ||
                    (cmd_opcode == regs_q[r][15:8]);
  end

  assign start_match = |hit;

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
  import ecc_pkg::*;
#(
  parameter int IDX_W  = 9,
  localparam int AW     = IDX_W + 3,
  localparam int CODE_W = 2 * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [7:0]        din,
  output logic [CODE_W-1:0] code_nxt
);

  logic [CODE_W-1:0] code_q;
  logic [2:0]        odd_col;
  logic [2:0]        even_col;
  logic              byte_par;
  logic [AW-1:0]     odd_term;
  logic [AW-1:0]     even_term;

  for (genvar k = 0; k < 3; k++) begin : g_col
    localparam logic [7:0] MK = bit_sel_mask(k);
    assign odd_col[k]  = ^(din & MK);
    assign even_col[k] = ^(din & ~MK);
  end

  assign byte_par  = ^din;
  assign odd_term  = {(byte_par ? byte_idx  : {IDX_W{1'b0}}), odd_col};
  assign even_term = {(byte_par ? ~byte_idx : {IDX_W{1'b0}}), even_col};

  always_comb begin
    code_nxt = code_q;
    if (en) begin
      code_nxt = code_q ^ {even_term, odd_term};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clear) begin
      code_q <= '0;
    end else begin
      code_q <= code_nxt;
    end
  end

endmodule

// File: rtl/ecc_result_bank.sv
module ecc_result_bank
  import ecc_pkg::*;
#(
  parameter int MAX_CHUNKS = 4,
  parameter int CODE_W     = 24,
  localparam int CH_W      = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int PAD_W     = CORR_BIT - CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_failed,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic [CODE_W-1:0] inv_q   [MAX_CHUNKS];
  logic              valid_q [MAX_CHUNKS];
  logic              fail_q  [MAX_CHUNKS];
  logic [WORD_W-1:0] word    [MAX_CHUNKS];

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inv_q[c]   <= '0;
        valid_q[c] <= 1'b0;
        fail_q[c]  <= 1'b0;
      end else if (clear) begin
        inv_q[c]   <= '0;
        valid_q[c] <= 1'b0;
        fail_q[c]  <= 1'b0;
      end else if (wr_en && (wr_idx == CH_W'(c))) begin
        inv_q[c]   <= ~wr_code;
        valid_q[c] <= 1'b1;
        fail_q[c]  <= wr_failed;
      end
    end

    assign word[c] = {1'b0, valid_q[c], 1'b0, fail_q[c], 1'b0,
                      {PAD_W{1'b0}}, inv_q[c]};
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < MAX_CHUNKS; c++) begin
      if (rd_idx == CH_W'(c)) rd_data = word[c];
    end
  end

endmodule

// File: rtl/ecc_page_gen.sv
module ecc_page_gen
  import ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_CHUNKS  = 4,
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int CODE_W = 2 * (IDX_W + 3),
  localparam int CH_W   = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int CC_W   = $clog2(MAX_CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_q,
  input  logic              op_we,
  input  logic              op_sel,
  input  logic [31:0]       op_wdata,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_opcode,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [7:0]        dat_byte,
  input  logic              dat_last,
  output logic              busy,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic              start_match;
  logic              mode_on;
  logic              start;
  logic              bypass_wr;
  logic              accept;
  logic              in_page;
  logic              feed;
  logic              chunk_full;
  logic              last_acc;
  logic              publish;
  logic              restart;
  logic [CC_W-1:0]   page_chunks;
  logic [CC_W-1:0]   chunk_q;
  logic [IDX_W-1:0]  byte_cnt_q;
  logic [CODE_W-1:0] code_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign mode_on   = ecc_mode_e'(cfg_q[3:2]) != MODE_BYPASS;
  assign bypass_wr = cfg_we && (ecc_mode_e'(cfg_wdata[3:2]) == MODE_BYPASS);

  always_comb begin
    int n;
    case (cfg_q[1:0])
      2'd1:    n = 1;
      2'd2:    n = 2;
      default: n = 4;
    endcase
    if (n > MAX_CHUNKS) n = MAX_CHUNKS;
    page_chunks = CC_W'(n);
  end

  ecc_opcode_regs u_ops (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_we       (op_we),
    .op_sel      (op_sel),
    .op_wdata    (op_wdata),
    .cmd_opcode  (cmd_opcode),
    .start_match (start_match)
  );

  assign start      = cmd_valid && mode_on && start_match;
  assign dat_ready  = !start;
  assign accept     = dat_valid && dat_ready;
  assign in_page    = busy && (chunk_q < page_chunks);
  assign feed       = accept && in_page;
  assign chunk_full = feed && (byte_cnt_q == IDX_W'(CHUNK_BYTES - 1));
  assign last_acc   = accept && dat_last && busy;
  assign publish    = chunk_full || (last_acc && in_page);
  assign restart    = start || bypass_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      chunk_q    <= '0;
      byte_cnt_q <= '0;
    end else if (bypass_wr) begin
      busy       <= 1'b0;
      chunk_q    <= '0;
      byte_cnt_q <= '0;
    end else if (start) begin
      busy       <= 1'b1;
      chunk_q    <= '0;
      byte_cnt_q <= '0;
    end else begin
      if (last_acc) busy <= 1'b0;
      if (chunk_full) begin
        chunk_q    <= chunk_q + 1'b1;
        byte_cnt_q <= '0;
      end else if (last_acc) begin
        byte_cnt_q <= '0;
      end else if (feed) begin
        byte_cnt_q <= byte_cnt_q + 1'b1;
      end
    end
  end

  ecc_parity_acc #(.IDX_W(IDX_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart || publish),
    .en       (feed),
    .byte_idx (byte_cnt_q),
    .din      (dat_byte),
    .code_nxt (code_nxt)
  );

  ecc_result_bank #(.MAX_CHUNKS(MAX_CHUNKS), .CODE_W(CODE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (restart),
    .wr_en     (publish),
    .wr_idx    (CH_W'(chunk_q)),
    .wr_code   (code_nxt),
    .wr_failed (!chunk_full),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/ecc_page_gen_chk.sv
module ecc_page_gen_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [3:0]      cfg_wdata,
  input logic            cmd_valid,
  input logic            dat_valid,
  input logic            dat_ready,
  input logic            dat_last,
  input logic            busy,
  input logic [CH_W-1:0] rd_idx,
  input logic [31:0]     rd_data
);

  // R3: busy only rises after a command cycle
  p_start_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R4: back-pressure only while a command is present
  p_ready_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_ready |-> cmd_valid);

  // R9: busy falls only after an accepted last beat or a configuration write
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((dat_valid && dat_ready && dat_last) || cfg_we));

  // R6: unused bits stay clear and failed never appears without valid
  p_word_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] == 1'b0) && (rd_data[29] == 1'b0) && (rd_data[27:24] == 4'd0) &&
    (!rd_data[28] || rd_data[30]));

  // R10: a bypass write ends any page
  p_bypass_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[3:2] == 2'd0) |=> !busy);

  // R11: while idle with no command or configuration, results do not move
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid && !cfg_we) |=> (!$stable(rd_idx) || $stable(rd_data)));

endmodule

bind ecc_page_gen ecc_page_gen_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cmd_valid (cmd_valid),
  .dat_valid (dat_valid),
  .dat_ready (dat_ready),
  .dat_last  (dat_last),
  .busy      (busy),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data)
);

// File: tb/ecc_page_gen_tb.sv
module ecc_page_gen_tb;

  localparam int CB = 512;
  localparam int MC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_q;
  logic        op_we = 1'b0;
  logic        op_sel = 1'b0;
  logic [31:0] op_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_opcode = '0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        dat_last = 1'b0;
  logic        busy;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  ecc_page_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .op_we(op_we), .op_sel(op_sel), .op_wdata(op_wdata),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte), .dat_last(dat_last),
    .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  typedef struct {
    int          idx;
    logic [31:0] word;
    string       req;
  } exp_t;

  exp_t        scb[$];
  logic [7:0]  pg [0:2047];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic        rdy_seen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * (seed | 1)) ^ (i >> 3) ^ (seed * 37) ^ (i >> 9));
  endfunction

  // Reference code per R5, straight from the bit-address definition.
  function automatic logic [23:0] ref_code(input int base, input int len);
    logic [11:0] odd = '0, even = '0, a;
    for (int i = 0; i < len; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (pg[base + i][j]) begin
          a = {9'(i), 3'(j)};
          odd  ^= a;
          even ^= ~a;
        end
      end
    end
    return {even, odd};
  endfunction

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_op(input logic sel, input logic [31:0] v);
    @(negedge clk); op_we = 1'b1; op_sel = sel; op_wdata = v;
    @(negedge clk); op_we = 1'b0;
  endtask

  task automatic issue_cmd(input logic [7:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_opcode = op;
    #1 rdy_seen = dat_ready;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_stream(input int n, input int seed, input bit last, input bit store);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_valid = 1'b1;
      dat_byte  = pat(seed, i);
      dat_last  = last && (i == n - 1);
      if (store) pg[i] = dat_byte;
    end
    @(negedge clk); dat_valid = 1'b0; dat_last = 1'b0;
  endtask

  // Driver side of the scoreboard: expected result words for a page.
  task automatic push_page(input int n, input int chunks, input string req);
    exp_t e;
    for (int c = 0; c < MC; c++) begin
      int base = c * CB;
      e.idx = c; e.req = req;
      if (c < chunks && base < n) begin
        int len = (n - base > CB) ? CB : n - base;
        e.word = {1'b0, 1'b1, 1'b0, (len < CB), 4'b0, ~ref_code(base, len)};
      end else begin
        e.word = '0;
      end
      scb.push_back(e);
    end
  endtask

  task automatic push_zero(input string req);
    exp_t e;
    for (int c = 0; c < MC; c++) begin
      e.idx = c; e.word = '0; e.req = req;
      scb.push_back(e);
    end
  endtask

  // Monitor side: pop each expectation and compare with the selected word.
  task automatic monitor_drain();
    exp_t e;
    while (scb.size() > 0) begin
      e = scb.pop_front();
      @(negedge clk); rd_idx = 2'(e.idx);
      #1 check(e.req, rd_data, e.word);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 cfg", 32'(cfg_q), 0);
    push_zero("R1 result after reset");
    monitor_drain();

    // R3: in bypass a start opcode does nothing
    issue_cmd(8'h80);
    check("R4 ready in bypass", 32'(rdy_seen), 1);
    @(negedge clk);
    check("R3 no start in bypass", 32'(busy), 0);

    // R2 configuration readback: register mode, 2 KiB
    write_cfg(4'b0111);
    check("R2 cfg readback", 32'(cfg_q), 32'h7);

    // R4 ready stays high with a non-start command and with idle data
    issue_cmd(8'h30);
    check("R4 ready non-start cmd", 32'(rdy_seen), 1);
    @(negedge clk);
    check("R3 read-end opcode does not start", 32'(busy), 0);

    // Full 2 KiB page with the reset write-start opcode
    issue_cmd(8'h80);
    check("R4 ready low on start", 32'(rdy_seen), 0);
    check("R3 busy after start", 32'(busy), 1);
    send_stream(2048, 3, 1, 1);
    check("R9 busy drop after last", 32'(busy), 0);
    push_page(2048, 4, "R7 full page chunk");
    monitor_drain();

    // R11: idle bytes with last change nothing
    push_page(2048, 4, "R11 results after idle bytes");
    send_stream(40, 9, 1, 0);
    check("R11 busy stays low", 32'(busy), 0);
    monitor_drain();

    // Reprogrammed read-start opcode, memory mode, 512 B page, extra bytes
    write_op(1'b0, 32'h0130_3C80);
    write_cfg(4'b1001);
    issue_cmd(8'h3C);
    check("R3 programmed opcode starts", 32'(busy), 1);
    send_stream(700, 5, 1, 1);
    check("R9 busy low after long page", 32'(busy), 0);
    push_page(700, 1, "R8 bytes past page ignored");
    monitor_drain();

    // Partial second chunk, 1 KiB page, start via register 1 byte 0
    write_cfg(4'b0110);
    issue_cmd(8'h85);
    send_stream(600, 11, 1, 1);
    push_page(600, 2, "R9 partial chunk failed");
    monitor_drain();

    // Page size 0 maps to four chunks
    write_cfg(4'b0100);
    issue_cmd(8'h05);
    send_stream(1536, 17, 1, 1);
    push_page(1536, 4, "R2 page size 0 four chunks");
    monitor_drain();

    // Single-byte page with a non-trivial byte: code and flags layout
    write_cfg(4'b0101);
    issue_cmd(8'h80);
    send_stream(1, 2, 1, 1);
    push_page(1, 1, "R5 R6 single byte code");
    monitor_drain();

    // R10 bypass mid-page
    write_cfg(4'b0111);
    issue_cmd(8'h80);
    send_stream(100, 21, 0, 1);
    check("R10 busy before bypass", 32'(busy), 1);
    write_cfg(4'b0011);
    check("R10 busy cleared", 32'(busy), 0);
    push_zero("R10 results cleared");
    monitor_drain();

    finish_run();
  end

endmodule